// File: doc/BRIEF.md
# Physical Register Rename Unit

This unit translates the logical register names of a decoded instruction stream into physical register numbers, so that writes to one logical register no longer have to wait for earlier readers and writers of it. It keeps two mapping tables and a pool of unallocated physical registers. The speculative table describes the newest renamed state. The committed table describes the state after the youngest retired instruction. The pool is a first-in first-out queue of physical register numbers.

Each cycle the front end may present one instruction with two logical sources and one logical destination. The sources are translated through the speculative table. The destination receives the physical register at the head of the pool, and the speculative table is updated to point at it. When an instruction retires, the back end presents its logical destination and the physical register it was given. The committed table takes the new number, and the physical register that it held before is put back at the tail of the pool. No register value is moved anywhere. On a flush the speculative table is overwritten with the committed table, and a control state machine rebuilds the pool by scanning every physical register number.

The controller has two named states. RECLAIM stalls renaming and walks all physical register numbers in ascending order, pushing each one that the committed table does not use. RUN is normal operation. Reset enters RECLAIM. The transition RECLAIM to RUN happens after the last physical number has been scanned. The transition RUN to RECLAIM, or RECLAIM to RECLAIM with a restarted scan, happens on a recovery request.

Top module: `rename_unit`

## Requirements
- R1: At reset logical register n maps to physical register n in both tables, and renamed sources of the first instructions after reset return their own logical numbers.
- R2: Each accepted rename receives the physical register at the head of the pool. After reset the pool holds the numbers above the logical count in ascending order, so the first destinations are 32, 33, 34 and so on.
- R3: The stall output is high whenever the pool is empty. A rename presented while stall is high is not accepted and changes neither table nor the pool.
- R4: Both sources are read from the speculative table before the same cycle's destination update, so an instruction reading its own destination register sees the older mapping. Later instructions see the new one.
- R5: A commit writes the given physical number into the committed table entry of the given logical register and leaves the speculative table unchanged.
- R6: A commit appends the physical register that the committed table held before for that logical register to the tail of the pool.
- R7: The controller stays in RECLAIM, with stall high, for one cycle per physical register (64 cycles by default) after reset or after a recovery request, and then moves to RUN.
- R8: A recovery request copies the committed table into the speculative table and refills the pool in ascending order with every physical number that the committed table does not use. Commits are not presented in the recovery cycle or during RECLAIM.
- R9: The number of renamed but uncommitted instructions can never exceed the number of physical registers beyond the logical count (32 by default).
- R10: A rename and a commit in the same cycle both take effect, and the pool occupancy stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid_i | input | 1 | An instruction is presented for renaming |
| ren_src1_log_i | input | 5 | Logical number of the first source |
| ren_src2_log_i | input | 5 | Logical number of the second source |
| ren_dst_log_i | input | 5 | Logical number of the destination |
| ren_stall_o | output | 1 | Rename not accepted this cycle |
| ren_src1_phys_o | output | 6 | Physical number of the first source |
| ren_src2_phys_o | output | 6 | Physical number of the second source |
| ren_dst_phys_o | output | 6 | Physical number given to the destination |
| cmt_valid_i | input | 1 | An instruction retires this cycle |
| cmt_log_i | input | 5 | Logical destination of the retiring instruction |
| cmt_phys_i | input | 6 | Physical register the retiring instruction was given |
| recover_i | input | 1 | Flush request: restore the speculative state from the committed state |

## Verification
The bench drains the pool completely and then retires one instruction. A design that loses the stalled request, or puts the freed register in the wrong place, hands out the wrong number at that point. It renames instructions whose sources name their own destination, and it overlaps retirement with renaming for long stretches. Reading the table after the write, or dropping one of two simultaneous pool updates, shows up as wrong source numbers or as a stall that comes too early or too late. After a flush it compares every renamed source against the committed mapping and the refilled destinations against the ascending set of unused numbers. A rebuild that leaks registers, or one that counts a committed register twice, is caught there.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [0:0] {
        ST_RECLAIM = 1'b0,
        ST_RUN     = 1'b1
    } rn_state_e;

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_ENT = 32,
    parameter int ENT_W   = 6,
    parameter int NUM_RD  = 2,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_i  [NUM_RD],
    output logic [ENT_W-1:0] rd_val_o  [NUM_RD],
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [ENT_W-1:0] wr_val_i,
    input  logic             load_en_i,
    input  logic [ENT_W-1:0] load_tbl_i [NUM_ENT],
    output logic [ENT_W-1:0] tbl_o     [NUM_ENT]
);

    logic [ENT_W-1:0] tbl_q [NUM_ENT];

    // Identity mapping at reset; a bulk load wins over a single write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ENT; e++) begin
                tbl_q[e] <= ENT_W'(e);
            end
        end else if (load_en_i) begin
            tbl_q <= load_tbl_i;
        end else if (wr_en_i) begin
            tbl_q[wr_idx_i] <= wr_val_i;
        end
    end

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        assign rd_val_o[g] = tbl_q[rd_idx_i[g]];
    end

    assign tbl_o = tbl_q;

endmodule

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 6,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              empty_o
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_i && !clear_i) begin
            mem_q[wr_ptr_q] <= push_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (clear_i) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            unique case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_o  = mem_q[rd_ptr_q];
    assign count_o = cnt_q;
    assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/rn_reclaim_ctrl.sv
module rn_reclaim_ctrl
    import rn_pkg::*;
#(
    parameter int NUM_LOG  = 32,
    parameter int NUM_PHYS = 64,
    parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                recover_i,
    input  logic [NUM_PHYS-1:0] used_mask_i,
    output logic                busy_o,
    output logic                clear_o,
    output logic                spec_load_o,
    output logic                push_o,
    output logic [PHYS_W-1:0]   push_phys_o,
    output rn_state_e           state_o
);

    localparam logic [PHYS_W-1:0]   LAST_IDX   = PHYS_W'(NUM_PHYS - 1);
    localparam logic [NUM_PHYS-1:0] RESET_MASK =
        {{(NUM_PHYS - NUM_LOG){1'b0}}, {NUM_LOG{1'b1}}};

    rn_state_e           state_q, state_nxt;
    logic [PHYS_W-1:0]   idx_q;
    logic [NUM_PHYS-1:0] mask_q;

    // State register, scan index and snapshot of the committed usage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RECLAIM;
            idx_q   <= '0;
            mask_q  <= RESET_MASK;
        end else begin
            state_q <= state_nxt;
            if (recover_i) begin
                idx_q  <= '0;
                mask_q <= used_mask_i;
            end else if (state_q == ST_RECLAIM) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Transitions: RUN->RECLAIM on recovery, RECLAIM restarts on recovery,
    // RECLAIM->RUN once the last physical number has been scanned.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (recover_i) state_nxt = ST_RECLAIM;
            end
            ST_RECLAIM: begin
                if (recover_i)             state_nxt = ST_RECLAIM;
                else if (idx_q == LAST_IDX) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RECLAIM;
        endcase
    end

    // Outputs.
    always_comb begin
        busy_o      = 1'b0;
        push_o      = 1'b0;
        clear_o     = recover_i;
        spec_load_o = recover_i;
        push_phys_o = idx_q;
        unique case (state_q)
            ST_RUN: begin
                busy_o = 1'b0;
            end
            ST_RECLAIM: begin
                busy_o = 1'b1;
                push_o = !recover_i && !mask_q[idx_q];
            end
            default: busy_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rn_pkg::*;
#(
    parameter int NUM_LOG  = 32,
    parameter int NUM_PHYS = 64,
    parameter int LOG_W    = $clog2(NUM_LOG),
    parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid_i,
    input  logic [LOG_W-1:0]  ren_src1_log_i,
    input  logic [LOG_W-1:0]  ren_src2_log_i,
    input  logic [LOG_W-1:0]  ren_dst_log_i,
    output logic              ren_stall_o,
    output logic [PHYS_W-1:0] ren_src1_phys_o,
    output logic [PHYS_W-1:0] ren_src2_phys_o,
    output logic [PHYS_W-1:0] ren_dst_phys_o,
    input  logic              cmt_valid_i,
    input  logic [LOG_W-1:0]  cmt_log_i,
    input  logic [PHYS_W-1:0] cmt_phys_i,
    input  logic              recover_i
);

    localparam int POOL_DEPTH = NUM_PHYS - NUM_LOG;
    localparam int CNT_W      = $clog2(POOL_DEPTH + 1);

    logic [LOG_W-1:0]    spec_rd_idx [2];
    logic [PHYS_W-1:0]   spec_rd_val [2];
    logic [PHYS_W-1:0]   spec_tbl    [NUM_LOG];
    logic [LOG_W-1:0]    cmt_rd_idx  [1];
    logic [PHYS_W-1:0]   cmt_rd_val  [1];
    logic [PHYS_W-1:0]   cmt_tbl     [NUM_LOG];
    logic [NUM_PHYS-1:0] used_mask;
    logic [PHYS_W-1:0]   pool_head;
    logic [CNT_W-1:0]    pool_cnt;
    logic                pool_empty;
    logic                busy, pool_clear, spec_load, scan_push;
    logic [PHYS_W-1:0]   scan_phys;
    logic                pool_push;
    logic [PHYS_W-1:0]   pool_push_data;
    logic                ren_fire;
    rn_state_e           ctrl_state;

    assign spec_rd_idx[0] = ren_src1_log_i;
    assign spec_rd_idx[1] = ren_src2_log_i;
    assign cmt_rd_idx[0]  = cmt_log_i;

    assign ren_stall_o = busy | pool_empty | recover_i;
    assign ren_fire    = ren_valid_i & ~ren_stall_o;

    rn_map_table #(
        .NUM_ENT (NUM_LOG),
        .ENT_W   (PHYS_W),
        .NUM_RD  (2)
    ) spec_map_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_i   (spec_rd_idx),
        .rd_val_o   (spec_rd_val),
        .wr_en_i    (ren_fire),
        .wr_idx_i   (ren_dst_log_i),
        .wr_val_i   (pool_head),
        .load_en_i  (spec_load),
        .load_tbl_i (cmt_tbl),
        .tbl_o      (spec_tbl)
    );

    rn_map_table #(
        .NUM_ENT (NUM_LOG),
        .ENT_W   (PHYS_W),
        .NUM_RD  (1)
    ) cmt_map_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_i   (cmt_rd_idx),
        .rd_val_o   (cmt_rd_val),
        .wr_en_i    (cmt_valid_i),
        .wr_idx_i   (cmt_log_i),
        .wr_val_i   (cmt_phys_i),
        .load_en_i  (1'b0),
        .load_tbl_i (spec_tbl),
        .tbl_o      (cmt_tbl)
    );

    // Physical numbers held by the committed table.
    always_comb begin
        used_mask = '0;
        for (int e = 0; e < NUM_LOG; e++) begin
            used_mask[cmt_tbl[e]] = 1'b1;
        end
    end

    rn_reclaim_ctrl #(
        .NUM_LOG  (NUM_LOG),
        .NUM_PHYS (NUM_PHYS)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .recover_i   (recover_i),
        .used_mask_i (used_mask),
        .busy_o      (busy),
        .clear_o     (pool_clear),
        .spec_load_o (spec_load),
        .push_o      (scan_push),
        .push_phys_o (scan_phys),
        .state_o     (ctrl_state)
    );

    // Scan pushes and commit frees never coincide: no commit in RECLAIM.
    assign pool_push      = scan_push | cmt_valid_i;
    assign pool_push_data = scan_push ? scan_phys : cmt_rd_val[0];

    rn_free_fifo #(
        .DEPTH  (POOL_DEPTH),
        .DATA_W (PHYS_W)
    ) pool_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (pool_clear),
        .push_i      (pool_push),
        .push_data_i (pool_push_data),
        .pop_i       (ren_fire),
        .head_o      (pool_head),
        .count_o     (pool_cnt),
        .empty_o     (pool_empty)
    );

    assign ren_src1_phys_o = spec_rd_val[0];
    assign ren_src2_phys_o = spec_rd_val[1];
    assign ren_dst_phys_o  = pool_head;

endmodule

// File: rtl/rn_checker.sv
module rn_checker
    import rn_pkg::*;
#(
    parameter int NUM_LOG  = 32,
    parameter int NUM_PHYS = 64,
    parameter int LOG_W    = $clog2(NUM_LOG),
    parameter int PHYS_W   = $clog2(NUM_PHYS),
    parameter int CNT_W    = $clog2(NUM_PHYS - NUM_LOG + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ren_fire,
    input logic                ren_stall_o,
    input logic [PHYS_W-1:0]   ren_dst_phys_o,
    input logic                cmt_valid_i,
    input logic [LOG_W-1:0]    cmt_log_i,
    input logic [PHYS_W-1:0]   cmt_phys_i,
    input logic                recover_i,
    input logic                busy,
    input logic [CNT_W-1:0]    pool_cnt,
    input logic [NUM_PHYS-1:0] used_mask,
    input logic [PHYS_W-1:0]   spec_tbl [NUM_LOG],
    input logic [PHYS_W-1:0]   cmt_tbl  [NUM_LOG]
);

    localparam logic [CNT_W-1:0] POOL_MAX = CNT_W'(NUM_PHYS - NUM_LOG);

    logic              prev_cmt;
    logic [LOG_W-1:0]  prev_log;
    logic [PHYS_W-1:0] prev_phys;
    logic              maps_equal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_cmt  <= 1'b0;
            prev_log  <= '0;
            prev_phys <= '0;
        end else begin
            prev_cmt  <= cmt_valid_i;
            prev_log  <= cmt_log_i;
            prev_phys <= cmt_phys_i;
        end
    end

    always_comb begin
        maps_equal = 1'b1;
        for (int e = 0; e < NUM_LOG; e++) begin
            if (spec_tbl[e] != cmt_tbl[e]) maps_equal = 1'b0;
        end
    end

    // R2: an allocated destination is never a committed register.
    p_dst_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ren_fire |-> !used_mask[ren_dst_phys_o]);

    // R7: no rename is accepted while reclaiming.
    p_busy_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ren_stall_o);

    // R5: committed entry holds the retired register one cycle later.
    p_cmt_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prev_cmt |-> (cmt_tbl[prev_log] == prev_phys));

    // R6: a commit without a rename grows the pool by one.
    p_cmt_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid_i && !ren_fire && !recover_i) |=> (pool_cnt == $past(pool_cnt) + 1'b1));

    // R10: simultaneous rename and commit keep the pool occupancy.
    p_pool_balance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid_i && ren_fire && !recover_i) |=> (pool_cnt == $past(pool_cnt)));

    // R8: after recovery the speculative table equals the committed table.
    p_recover_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recover_i |=> maps_equal);

    // R8: commits are not presented while recovering or reclaiming.
    p_no_cmt_reclaim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || recover_i) |-> !cmt_valid_i);

    // R9: the pool never holds more than the extra registers.
    p_pool_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pool_cnt <= POOL_MAX);

    // R1: the committed table always names distinct registers.
    p_cmt_distinct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(used_mask) == NUM_LOG);

endmodule

bind rename_unit rn_checker #(
    .NUM_LOG  (NUM_LOG),
    .NUM_PHYS (NUM_PHYS)
) rn_checker_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ren_fire       (ren_fire),
    .ren_stall_o    (ren_stall_o),
    .ren_dst_phys_o (ren_dst_phys_o),
    .cmt_valid_i    (cmt_valid_i),
    .cmt_log_i      (cmt_log_i),
    .cmt_phys_i     (cmt_phys_i),
    .recover_i      (recover_i),
    .busy           (busy),
    .pool_cnt       (pool_cnt),
    .used_mask      (used_mask),
    .spec_tbl       (spec_tbl),
    .cmt_tbl        (cmt_tbl)
);

// File: tb/rename_unit_tb_top.sv
`timescale 1ns/1ps
module rename_unit_tb_top;

    localparam int NL = 32;
    localparam int NP = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid_i = 1'b0;
    logic [4:0] ren_src1_log_i = '0, ren_src2_log_i = '0, ren_dst_log_i = '0;
    logic       ren_stall_o;
    logic [5:0] ren_src1_phys_o, ren_src2_phys_o, ren_dst_phys_o;
    logic       cmt_valid_i = 1'b0;
    logic [4:0] cmt_log_i = '0;
    logic [5:0] cmt_phys_i = '0;
    logic       recover_i = 1'b0;

    always #4 clk = ~clk;

    rename_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .ren_valid_i(ren_valid_i), .ren_src1_log_i(ren_src1_log_i),
        .ren_src2_log_i(ren_src2_log_i), .ren_dst_log_i(ren_dst_log_i),
        .ren_stall_o(ren_stall_o), .ren_src1_phys_o(ren_src1_phys_o),
        .ren_src2_phys_o(ren_src2_phys_o), .ren_dst_phys_o(ren_dst_phys_o),
        .cmt_valid_i(cmt_valid_i), .cmt_log_i(cmt_log_i),
        .cmt_phys_i(cmt_phys_i), .recover_i(recover_i)
    );

    typedef struct {
        bit    ren;
        bit    stall;
        int    s1, s2, d;
        string tag;
        string stall_tag;
    } exp_t;

    exp_t  expq[$];
    int    smap[NL], cmap[NL];
    int    freeq[$];
    int    fl_log[$], fl_phys[$];
    int    busy_left;
    int    checks = 0, errors = 0;
    int    dut_fires = 0, n_commits = 0;
    bit    done = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NL; i++) begin
            smap[i] = i;
            cmap[i] = i;
        end
        freeq.delete();
        for (int p = NL; p < NP; p++) freeq.push_back(p);
        fl_log.delete();
        fl_phys.delete();
        busy_left = NP - 1;
    endtask

    // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
    task automatic drive(input bit ren, input int s1, input int s2, input int d,
                         input bit cmt, input bit rec, input string tag);
        exp_t e;
        int   clog, cphys, old;
        bit   used[NP];
        @(negedge clk);
        cmt = cmt && (fl_log.size() > 0) && !rec && (busy_left == 0);
        clog = 0;
        cphys = 0;
        if (cmt) begin
            clog  = fl_log.pop_front();
            cphys = fl_phys.pop_front();
        end
        ren_valid_i    = ren;
        ren_src1_log_i = 5'(s1);
        ren_src2_log_i = 5'(s2);
        ren_dst_log_i  = 5'(d);
        cmt_valid_i    = cmt;
        cmt_log_i      = 5'(clog);
        cmt_phys_i     = 6'(cphys);
        recover_i      = rec;
        e.ren   = ren;
        e.tag   = tag;
        e.stall = rec || (busy_left > 0) || (freeq.size() == 0);
        e.stall_tag = (busy_left > 0) ? "R7" : (rec ? "R8" : "R3");
        e.s1 = 0; e.s2 = 0; e.d = 0;
        if (ren && !e.stall) begin
            e.s1 = smap[s1];
            e.s2 = smap[s2];
            e.d  = freeq.pop_front();
            smap[d] = e.d;
            fl_log.push_back(d);
            fl_phys.push_back(e.d);
        end
        if (cmt) begin
            old = cmap[clog];
            cmap[clog] = cphys;
            freeq.push_back(old);
            n_commits++;
        end
        if (rec) begin
            for (int i = 0; i < NL; i++) smap[i] = cmap[i];
            for (int p = 0; p < NP; p++) used[p] = 0;
            for (int i = 0; i < NL; i++) used[cmap[i]] = 1;
            freeq.delete();
            for (int p = 0; p < NP; p++) if (!used[p]) freeq.push_back(p);
            fl_log.delete();
            fl_phys.delete();
            busy_left = NP;
        end else if (busy_left > 0) begin
            busy_left--;
        end
        expq.push_back(e);
    endtask

    // Monitor: compares the design against the scoreboard each cycle.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (ren_valid_i && !ren_stall_o) dut_fires++;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                chk(e.stall_tag, "stall", int'(ren_stall_o), int'(e.stall));
                if (e.ren && !e.stall) begin
                    chk(e.tag, "src1", int'(ren_src1_phys_o), e.s1);
                    chk(e.tag, "src2", int'(ren_src2_phys_o), e.s2);
                    chk(e.tag, "dst",  int'(ren_dst_phys_o),  e.d);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        int inflight;
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "stall in reset", int'(ren_stall_o), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: RECLAIM after reset stalls renaming.
        for (int i = 0; i < NP - 1; i++) drive(1, 0, 0, 0, 0, 0, "R7");

        // R1 identity sources, R2 ascending destinations from 32.
        drive(1, 2, 3, 1, 0, 0, "R1");
        drive(1, 4, 5, 3, 0, 0, "R2");
        // R4: sources see earlier destinations; own destination reads old.
        drive(1, 1, 3, 1, 0, 0, "R4");
        drive(1, 5, 5, 5, 0, 0, "R4");
        drive(1, 1, 5, 7, 0, 0, "R4");
        // R10: rename overlapping with commit.
        drive(1, 7, 1, 9, 1, 0, "R10");
        drive(1, 9, 3, 2, 1, 0, "R10");
        // R5: commits leave the speculative table alone.
        drive(0, 0, 0, 0, 1, 0, "R5");
        drive(1, 1, 9, 10, 0, 0, "R5");
        drive(0, 0, 0, 0, 1, 0, "R6");

        // R3 / R9: exhaust the pool without retiring.
        for (int i = 0; i < 40; i++) drive(1, i % NL, (i + 3) % NL, (i * 7) % NL, 0, 0, "R3");
        @(negedge clk); #3;
        inflight = dut_fires - n_commits;
        chk("R9", "in-flight at stall", inflight, NP - NL);
        // R6: freed register comes back through the pool tail.
        drive(1, 0, 0, 4, 1, 0, "R6");
        drive(1, 6, 4, 8, 0, 0, "R6");
        drive(1, 6, 4, 8, 1, 0, "R6");

        // R8: flush, reclaim, then rename against the committed state.
        drive(1, 1, 2, 3, 0, 1, "R8");
        for (int i = 0; i < NP; i++) drive(1, 0, 0, 0, 0, 0, "R7");
        for (int i = 0; i < NL; i++) drive(1, i, NL - 1 - i, i, 0, 0, "R8");

        // Mixed traffic with in-order retirement.
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(lf[0] | lf[1], int'(lf[6:2]), int'(lf[11:7]), int'(lf[15:11]),
                  lf[3] | lf[8], 0, "R10");
            if (i == 300) begin
                drive(0, 0, 0, 0, 0, 1, "R8");
                for (int k = 0; k < NP; k++) drive(0, 0, 0, 0, 0, 0, "R7");
            end
        end

        @(negedge clk);
        #3;
        chk("R10", "scoreboard drained", expq.size(), 0);
        finish_run();
    end

endmodule